// File: doc/BRIEF.md
# Power-On Strap Capture and Frequency Select

This block sits at the front of a clock generator's divider logic. While the power-on reset is held, it samples a small group of dual-purpose pins, four frequency straps and one graphics-port speed strap, into a holding register on every clock edge. When reset is released the register freezes, and the block asserts an output enable that hands the same pins over to their clock output drivers.

After release the block produces two registered results for the dividers. The first is a 5-bit frequency-select index, taken either from the frozen straps or from a 5-bit software value, depending on a source-select control bit. The second is an effective graphics-port speed select, which is the frozen strap level, optionally inverted by a toggle control bit. The block also reports the frozen frequency straps in inverted form so that software can read them back. Both results change only on a rising clock edge.

Top module: `strap_freq_select`

## Requirements
- R1: While `porN` is low, each rising clock edge loads `pinIn` into the holding register. `strapFs[i]` reports `pinIn[i]` for i = 0..3, and `strapAgp` reports `pinIn[4]`, as sampled at the last edge before release.
- R2: Once `porN` is high, the holding register does not change, whatever `pinIn` does.
- R3: `pinOe` is 0 while `porN` is low. It is 1 from the first rising edge at which `porN` is sampled high.
- R4: With `softSrc` = 0, `effSel` equals {1'b0, strapFs[3:0]}: bit i is frequency strap i for i = 0..3, and bit 4 is 0.
- R5: With `softSrc` = 1, `effSel` equals `softSel[4:0]`, bit for bit.
- R6: `fsReadback[i]` is the logical inverse of `strapFs[i]` for every i.
- R7: `effAgp` equals `strapAgp` when `agpToggle` = 0, and equals its inverse when `agpToggle` = 1.
- R8: A change on `softSrc`, `softSel` or `agpToggle` reaches `effSel` and `effAgp` only at the next rising edge, never earlier in the same cycle.
- R9: While `porN` is low, `effSel` is 0 and `effAgp` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| porN | input | 1 | Power-on reset, active low; the straps are sampled while it is low |
| pinIn | input | 5 | Strap pin levels: [3:0] are frequency straps, [4] is the graphics speed strap |
| softSrc | input | 1 | 0 selects the frozen straps, 1 selects the software index |
| softSel | input | 5 | Software frequency-select index |
| agpToggle | input | 1 | 1 inverts the graphics speed select |
| pinOe | output | 1 | Output enable that hands the strap pins to their clock drivers |
| strapFs | output | 4 | Frozen frequency strap levels |
| strapAgp | output | 1 | Frozen graphics speed strap level |
| fsReadback | output | 4 | Inverted frequency straps for readback |
| effSel | output | 5 | Registered effective frequency-select index |
| effAgp | output | 1 | Registered effective graphics speed select |

## Verification
Two things can happen in the same cycle: reset is released, and the strap-to-output handover takes place while the pins are still driven. The bench changes `pinIn` right after release and requires the frozen values, `effSel` and `effAgp` all to keep the reset-time pattern. A second collision is a software change of source or toggle landing mid-cycle. The bench sweeps all 32 strap patterns, changes the controls between edges, and checks that the outputs still hold the old value before the edge and the new value after it.

// File: rtl/strap_pkg.sv
package strap_pkg;

  // Strobes from the control to the datapath
  typedef struct packed {
    logic capture;  // load the strap pins on this edge
    logic drive;    // pins have been handed to the output drivers
  } strap_strobe_t;

  typedef enum logic {
    ST_SAMPLE = 1'b0,
    ST_RUN    = 1'b1
  } strap_state_e;

endpackage

// File: rtl/strap_ctrl.sv
module strap_ctrl
  import strap_pkg::*;
(
  input  logic          clk,
  input  logic          porN,
  output strap_strobe_t strb
);

  strap_state_e stateQ;

  // Leaves sampling on the first edge with reset released
  always_ff @(posedge clk or negedge porN) begin
    if (!porN) stateQ <= ST_SAMPLE;
    else       stateQ <= ST_RUN;
  end

  always_comb begin
    strb.capture = !porN;
    strb.drive   = (stateQ == ST_RUN);
  end

endmodule

// File: rtl/strap_dp.sv
module strap_dp
  import strap_pkg::*;
#(
  parameter int FS_W = 4
) (
  input  logic              clk,
  input  logic              porN,
  input  strap_strobe_t     strb,
  input  logic [FS_W:0]     pinIn,
  input  logic              softSrc,
  input  logic [FS_W:0]     softSel,
  input  logic              agpToggle,
  output logic [FS_W-1:0]   strapFs,
  output logic              strapAgp,
  output logic [FS_W-1:0]   fsReadback,
  output logic [FS_W:0]     effSel,
  output logic              effAgp
);

  localparam int PIN_W = FS_W + 1;
  localparam int IDX_W = FS_W + 1;
  localparam int AGP_BIT = FS_W;

  logic [PIN_W-1:0] strapQ;
  logic [IDX_W-1:0] hwIdx;
  logic [IDX_W-1:0] nextSel;
  logic             nextAgp;
  logic [IDX_W-1:0] selQ;
  logic             agpQ;

  // Holding register: follows the pins only while reset is asserted
  always_ff @(posedge clk) begin
    if (strb.capture) strapQ <= pinIn;
  end

  assign strapFs  = strapQ[FS_W-1:0];
  assign strapAgp = strapQ[AGP_BIT];

  // Readback inverts each strap bit
  for (genvar i = 0; i < FS_W; i++) begin : g_rb
    assign fsReadback[i] = ~strapQ[i];
  end

  // Hardware index: straps in the low bits, upper bit cleared
  assign hwIdx   = IDX_W'(strapQ[FS_W-1:0]);
  assign nextSel = softSrc ? softSel : hwIdx;
  assign nextAgp = strapQ[AGP_BIT] ^ agpToggle;

  always_ff @(posedge clk or negedge porN) begin
    if (!porN) begin
      selQ <= '0;
      agpQ <= 1'b0;
    end else begin
      selQ <= nextSel;
      agpQ <= nextAgp;
    end
  end

  assign effSel = selQ;
  assign effAgp = agpQ;

endmodule

// File: rtl/strap_freq_select.sv
module strap_freq_select
  import strap_pkg::*;
#(
  parameter int FS_W = 4
) (
  input  logic            clk,
  input  logic            porN,
  input  logic [FS_W:0]   pinIn,
  input  logic            softSrc,
  input  logic [FS_W:0]   softSel,
  input  logic            agpToggle,
  output logic            pinOe,
  output logic [FS_W-1:0] strapFs,
  output logic            strapAgp,
  output logic [FS_W-1:0] fsReadback,
  output logic [FS_W:0]   effSel,
  output logic            effAgp
);

  strap_strobe_t strb;

  strap_ctrl i_ctrl (
    .clk  (clk),
    .porN (porN),
    .strb (strb)
  );

  strap_dp #(.FS_W(FS_W)) i_dp (
    .clk        (clk),
    .porN       (porN),
    .strb       (strb),
    .pinIn      (pinIn),
    .softSrc    (softSrc),
    .softSel    (softSel),
    .agpToggle  (agpToggle),
    .strapFs    (strapFs),
    .strapAgp   (strapAgp),
    .fsReadback (fsReadback),
    .effSel     (effSel),
    .effAgp     (effAgp)
  );

  assign pinOe = strb.drive;

endmodule

// File: rtl/strap_freq_select_chk.sv
module strap_freq_select_chk #(
  parameter int FS_W = 4
) (
  input logic            clk,
  input logic            porN,
  input logic            softSrc,
  input logic [FS_W:0]   softSel,
  input logic            agpToggle,
  input logic            pinOe,
  input logic [FS_W-1:0] strapFs,
  input logic            strapAgp,
  input logic [FS_W-1:0] fsReadback,
  input logic [FS_W:0]   effSel,
  input logic            effAgp
);

  // R3: outputs are enabled one edge after reset is seen released
  a_r3_oe_after_release: assert property (@(posedge clk) disable iff (!porN)
    porN |=> pinOe);

  // R2: strap register is frozen in the run phase
  a_r2_latch_frozen: assert property (@(posedge clk) disable iff (!porN)
    pinOe |=> ($stable(strapFs) && $stable(strapAgp)));

  // R4: hardware source gives the zero-extended straps
  a_r4_hw_select: assert property (@(posedge clk) disable iff (!porN)
    (pinOe && !$past(softSrc)) |-> (effSel == {1'b0, $past(strapFs)}));

  // R5: software source gives the software index
  a_r5_soft_select: assert property (@(posedge clk) disable iff (!porN)
    (pinOe && $past(softSrc)) |-> (effSel == $past(softSel)));

  // R7: graphics speed select follows the strap, optionally inverted
  a_r7_agp_toggle: assert property (@(posedge clk) disable iff (!porN)
    pinOe |-> (effAgp == ($past(strapAgp) ^ $past(agpToggle))));

  // R6: readback bits are the inverse of the frozen straps
  a_r6_readback: assert property (@(posedge clk) disable iff (!porN)
    pinOe |-> ((fsReadback ^ strapFs) == {FS_W{1'b1}}));

endmodule

bind strap_freq_select strap_freq_select_chk #(.FS_W(FS_W)) i_chk (
  .clk        (clk),
  .porN       (porN),
  .softSrc    (softSrc),
  .softSel    (softSel),
  .agpToggle  (agpToggle),
  .pinOe      (pinOe),
  .strapFs    (strapFs),
  .strapAgp   (strapAgp),
  .fsReadback (fsReadback),
  .effSel     (effSel),
  .effAgp     (effAgp)
);

// File: tb/test_strap_freq_select.sv
module test_strap_freq_select;

  logic       clk = 1'b0;
  logic       porN = 1'b1;
  logic [4:0] pinIn = '0;
  logic       softSrc = 1'b0;
  logic [4:0] softSel = '0;
  logic       agpToggle = 1'b0;
  logic       pinOe;
  logic [3:0] strapFs;
  logic       strapAgp;
  logic [3:0] fsReadback;
  logic [4:0] effSel;
  logic       effAgp;

  int nChecks = 0;
  int nFails  = 0;
  int cycles  = 0;

  always #4 clk = ~clk;  // 125 MHz

  strap_freq_select i_strap_freq_select (
    .clk        (clk),
    .porN       (porN),
    .pinIn      (pinIn),
    .softSrc    (softSrc),
    .softSel    (softSel),
    .agpToggle  (agpToggle),
    .pinOe      (pinOe),
    .strapFs    (strapFs),
    .strapAgp   (strapAgp),
    .fsReadback (fsReadback),
    .effSel     (effSel),
    .effAgp     (effAgp)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      nFails++;
      $display("FAIL watchdog actual=%0d expected=done", cycles);
      $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    #1 porN = 1'b0;
    for (int p = 0; p < 32; p++) begin
      logic [4:0] pat;
      logic [4:0] sw;
      pat = 5'(p);
      sw  = pat ^ 5'h15;
      @(negedge clk);
      porN = 1'b0; softSrc = 1'b0; agpToggle = 1'b0;
      pinIn = ~pat;
      @(negedge clk);
      pinIn = pat;
      @(negedge clk);
      chk("R3 oe low in reset", 8'(pinOe), 8'd0);
      chk("R9 effSel in reset", 8'(effSel), 8'd0);
      chk("R9 effAgp in reset", 8'(effAgp), 8'd0);
      chk("R1 strapFs", 8'(strapFs), 8'(pat[3:0]));
      chk("R1 strapAgp", 8'(strapAgp), 8'(pat[4]));
      porN = 1'b1;
      @(negedge clk);
      chk("R3 oe after release", 8'(pinOe), 8'd1);
      chk("R4 hw index", 8'(effSel), 8'({1'b0, pat[3:0]}));
      chk("R7 agp no toggle", 8'(effAgp), 8'(pat[4]));
      chk("R6 readback", 8'(fsReadback), 8'(~pat[3:0] & 4'hf));
      pinIn = ~pat;  // pins now driven as outputs
      @(negedge clk);
      chk("R2 strapFs frozen", 8'(strapFs), 8'(pat[3:0]));
      chk("R2 strapAgp frozen", 8'(strapAgp), 8'(pat[4]));
      chk("R2 effSel unaffected", 8'(effSel), 8'({1'b0, pat[3:0]}));
      agpToggle = 1'b1;
      #1;
      chk("R8 agp holds before edge", 8'(effAgp), 8'(pat[4]));
      @(negedge clk);
      chk("R7 agp toggled", 8'(effAgp), 8'(~pat[4] & 1'b1));
      softSel = sw; softSrc = 1'b1;
      #1;
      chk("R8 sel holds before edge", 8'(effSel), 8'({1'b0, pat[3:0]}));
      @(negedge clk);
      chk("R5 soft index", 8'(effSel), 8'(sw));
      softSrc = 1'b0; agpToggle = 1'b0;
      @(negedge clk);
      chk("R4 back to hw", 8'(effSel), 8'({1'b0, pat[3:0]}));
      chk("R7 toggle cleared", 8'(effAgp), 8'(pat[4]));
    end
    $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule